// File: doc/BRIEF.md
# Lane-Parallel Carry/Borrow Vector Arithmetic Unit

This block performs one step of multi-precision unsigned arithmetic on every lane of a vector at once. Two packed vectors of `LANES` elements, each `ELEM_W` bits wide, arrive together with two per-lane bit vectors:

- a chain predicate, which is the carry-in for addition or the borrow-in for subtraction;
- an enable mask.

A single mode bit picks add-with-carry or subtract-with-borrow. Each lane is its own `ELEM_W`-bit adder with private carry-in and carry-out bits. No carry moves sideways between lanes inside one operation. Wider numbers are built across successive operations: software feeds the returned chain predicate vector back in as the next operation's chain input.

Results are registered. A small output controller has two states, `ST_IDLE` and `ST_SHOW`.

- `ST_IDLE`: no fresh result is presented.
- `ST_SHOW`: the result captured on the previous edge is presented, with `out_valid` high.
- Transition `T_LAUNCH` (any state to `ST_SHOW`) is taken on every edge that sees `in_valid` high, and the lane results are captured on that edge.
- Transition `T_RETIRE` (any state to `ST_IDLE`) is taken on an edge with `in_valid` low. The captured data is held.

Top module: `mpa_lane_array`

## Requirements
- R1: In add mode (`op_sub`=0), each active lane returns the low `ELEM_W` bits of a+b+cin, computed at `ELEM_W`+1 bits. Its `chain_out` bit is bit `ELEM_W` of that sum.
- R2: In subtract mode (`op_sub`=1), each active lane returns a−b−bin modulo 2^`ELEM_W`.
- R3: In subtract mode, an active lane's `chain_out` bit is 1 exactly when a < b+bin, compared unsigned at `ELEM_W`+1 bits. So b=all-ones with bin=1 always borrows.
- R4: A lane whose `lane_en` bit is 0 returns result 0 and `chain_out` 0, whatever its operands, chain bit and mode.
- R5: Lanes are independent. A carry or borrow produced in lane i has no effect on lane i+1 in the same operation.
- R6: `out_valid` is high in the cycle after each edge that samples `in_valid`=1. The matching `out_data` and `chain_out` appear in that same cycle.
- R7: After an edge with `in_valid`=0, `out_valid` is 0, and `out_data` and `chain_out` keep their previous values whatever the data inputs do.
- R8: While `rst_n` is low, and after it is released, `out_valid`, `out_data` and `chain_out` are all 0 until the first accepted operation.
- R9: Lane i occupies bits [i*`ELEM_W` +: `ELEM_W`] of `opa`, `opb` and `out_data`, and bit i of `chain_in`, `lane_en` and `chain_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe; inputs are sampled on this edge |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| opa | input | LANES*ELEM_W | First operand vector |
| opb | input | LANES*ELEM_W | Second operand vector |
| chain_in | input | LANES | Per-lane carry-in or borrow-in |
| lane_en | input | LANES | Per-lane active mask |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | LANES*ELEM_W | Truncated lane results |
| chain_out | output | LANES | Per-lane carry-out or borrow-out |

## Verification
The bench targets the following corner cases:

- **All-ones addition.** All-ones plus all-ones plus carry must give all-ones with a carry. A design that drops the extra bit loses the carry or wraps wrongly.
- **Borrow edge cases.**
  - 0−0−1 must return all-ones with a borrow.
  - all-ones − all-ones − 1 must also borrow. A comparison held to `ELEM_W` bits would wrap b+bin to zero and miss this borrow.
  - Equal operands with no borrow-in must give zero with no borrow.
- **Masked lanes.** Lanes carrying large operands and a set chain bit are masked off; any leak of the raw sum shows at the outputs.
- **Lane independence.** A lane that overflows sits next to a zero lane, which exposes any carry rippling between lanes.
- **Chaining.** A two-step chained addition is compared with a wide reference.
- **Hold behaviour.** Idle cycles with changing inputs catch an output register that reloads without a strobe.
- **Random mix.** Seeded random operations cover everything else.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } mpa_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } mpa_state_e;

endpackage

// File: rtl/mpa_lane.sv
module mpa_lane
    import mpa_pkg::*;
#(
    parameter int ELEM_W = 16
) (
    input  mpa_op_e           op,
    input  logic              active,
    input  logic              chain_bit,
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    output logic [ELEM_W-1:0] y,
    output logic              flag
);
    localparam int WIDE = ELEM_W + 1;

    logic [WIDE-1:0] a_x;
    logic [WIDE-1:0] b_x;
    logic [WIDE-1:0] c_x;
    logic [WIDE-1:0] sum_x;
    logic [WIDE-1:0] sub_rhs;
    logic [ELEM_W-1:0] diff;
    logic              borrow;

    always_comb begin
        a_x     = {1'b0, a};
        b_x     = {1'b0, b};
        c_x     = {{ELEM_W{1'b0}}, chain_bit};
        sum_x   = a_x + b_x + c_x;
        // subtrahend widened so b + borrow-in cannot wrap
        sub_rhs = b_x + c_x;
        diff    = a - b - c_x[ELEM_W-1:0];
        borrow  = (a_x < sub_rhs);
    end

    always_comb begin
        y    = '0;
        flag = 1'b0;
        if (active) begin
            unique case (op)
                OP_ADD: begin
                    y    = sum_x[ELEM_W-1:0];
                    flag = sum_x[ELEM_W];
                end
                OP_SUB: begin
                    y    = diff;
                    flag = borrow;
                end
                default: begin
                    y    = '0;
                    flag = 1'b0;
                end
            endcase
        end
    end

    // R4: a masked lane leaves nothing behind
    always_comb begin
        if (!active) begin
            a_masked_r4: assert (y == '0 && flag == 1'b0);
        end
    end

endmodule

// File: rtl/mpa_out_stage.sv
module mpa_out_stage
    import mpa_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int ELEM_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch,
    input  logic [LANES*ELEM_W-1:0] lane_y,
    input  logic [LANES-1:0]        lane_flag,
    output logic                    show,
    output logic [LANES*ELEM_W-1:0] held_y,
    output logic [LANES-1:0]        held_flag
);
    mpa_state_e state_q;
    mpa_state_e state_d;

    // next-state logic: T_LAUNCH / T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = launch ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = launch ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output process: data captured only on T_LAUNCH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_y    <= '0;
            held_flag <= '0;
        end else if (launch) begin
            held_y    <= lane_y;
            held_flag <= lane_flag;
        end
    end

    always_comb begin
        show = (state_q == ST_SHOW);
    end

    p_launch_shows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> show);
    p_idle_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> !show);
    p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> ($stable(held_y) && $stable(held_flag)));

endmodule

// File: rtl/mpa_lane_array.sv
module mpa_lane_array
    import mpa_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int ELEM_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    op_sub,
    input  logic [LANES*ELEM_W-1:0] opa,
    input  logic [LANES*ELEM_W-1:0] opb,
    input  logic [LANES-1:0]        chain_in,
    input  logic [LANES-1:0]        lane_en,
    output logic                    out_valid,
    output logic [LANES*ELEM_W-1:0] out_data,
    output logic [LANES-1:0]        chain_out
);
    localparam int VEC_W = LANES * ELEM_W;

    mpa_op_e          op_sel;
    logic [VEC_W-1:0] lane_y;
    logic [LANES-1:0] lane_flag;

    always_comb begin
        op_sel = op_sub ? OP_SUB : OP_ADD;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        mpa_lane #(.ELEM_W(ELEM_W)) u_lane (
            .op        (op_sel),
            .active    (lane_en[i]),
            .chain_bit (chain_in[i]),
            .a         (opa[i*ELEM_W +: ELEM_W]),
            .b         (opb[i*ELEM_W +: ELEM_W]),
            .y         (lane_y[i*ELEM_W +: ELEM_W]),
            .flag      (lane_flag[i])
        );

        // R1: registered sum and carry match the operands of the launch edge
        p_add_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_en[i] && !op_sub) |=>
            ({chain_out[i], out_data[i*ELEM_W +: ELEM_W]} ==
             ({1'b0, $past(opa[i*ELEM_W +: ELEM_W])} +
              {1'b0, $past(opb[i*ELEM_W +: ELEM_W])} +
              {{ELEM_W{1'b0}}, $past(chain_in[i])})));

        // R2: difference wraps modulo 2^ELEM_W
        p_sub_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_en[i] && op_sub) |=>
            (out_data[i*ELEM_W +: ELEM_W] ==
             ELEM_W'($past(opa[i*ELEM_W +: ELEM_W]) -
                     $past(opb[i*ELEM_W +: ELEM_W]) -
                     ELEM_W'($past(chain_in[i])))));
    end

    mpa_out_stage #(.LANES(LANES), .ELEM_W(ELEM_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (in_valid),
        .lane_y    (lane_y),
        .lane_flag (lane_flag),
        .show      (out_valid),
        .held_y    (out_data),
        .held_flag (chain_out)
    );

    // R4: flags never appear in lanes that were masked at the launch edge
    p_masked_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((chain_out & ~$past(lane_en)) == '0));

    // R8: nothing visible before the first accepted operation
    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_data == '0 && chain_out == '0));

endmodule

// File: tb/mpa_lane_array_test.sv
module mpa_lane_array_test;
    localparam int LANES  = 8;
    localparam int ELEM_W = 16;
    localparam int VEC_W  = LANES * ELEM_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             op_sub = 1'b0;
    logic [VEC_W-1:0] opa = '0;
    logic [VEC_W-1:0] opb = '0;
    logic [LANES-1:0] chain_in = '0;
    logic [LANES-1:0] lane_en = '0;
    logic             out_valid;
    logic [VEC_W-1:0] out_data;
    logic [LANES-1:0] chain_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [VEC_W-1:0] exp_y;
    logic [LANES-1:0] exp_f;

    always #4 clk = ~clk;

    mpa_lane_array #(.LANES(LANES), .ELEM_W(ELEM_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opa(opa), .opb(opb), .chain_in(chain_in), .lane_en(lane_en),
        .out_valid(out_valid), .out_data(out_data), .chain_out(chain_out)
    );

    function automatic void model(input logic sub, input logic [VEC_W-1:0] a,
                                  input logic [VEC_W-1:0] b, input logic [LANES-1:0] c,
                                  input logic [LANES-1:0] en,
                                  output logic [VEC_W-1:0] y, output logic [LANES-1:0] f);
        y = '0;
        f = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [ELEM_W:0] aw, bw, cw, s;
            aw = {1'b0, a[i*ELEM_W +: ELEM_W]};
            bw = {1'b0, b[i*ELEM_W +: ELEM_W]};
            cw = {{ELEM_W{1'b0}}, c[i]};
            if (en[i]) begin
                if (!sub) begin
                    s = aw + bw + cw;
                    y[i*ELEM_W +: ELEM_W] = s[ELEM_W-1:0];
                    f[i] = s[ELEM_W];
                end else begin
                    s = aw - bw - cw;
                    y[i*ELEM_W +: ELEM_W] = s[ELEM_W-1:0];
                    f[i] = (aw < bw + cw);
                end
            end
        end
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [VEC_W-1:0] act,
                             input logic [VEC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one operation, check it one cycle later, leave in_valid low
    task automatic run_op(input string req, input logic sub, input logic [VEC_W-1:0] a,
                          input logic [VEC_W-1:0] b, input logic [LANES-1:0] c,
                          input logic [LANES-1:0] en);
        @(negedge clk);
        in_valid = 1'b1; op_sub = sub; opa = a; opb = b; chain_in = c; lane_en = en;
        model(sub, a, b, c, en, exp_y, exp_f);
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R6 valid", out_valid, 1'b1);
        check_vec(req, out_data, exp_y);
        check_vec({req, " flags"}, VEC_W'(chain_out), VEC_W'(exp_f));
    endtask

    function automatic logic [VEC_W-1:0] fill(input logic [ELEM_W-1:0] v);
        return {LANES{v}};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [VEC_W-1:0] a, b, lo_y, ref_y;
        logic [LANES-1:0] lo_f;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R8: reset state
        check_bit("R8 valid", out_valid, 1'b0);
        check_vec("R8 data", out_data, '0);
        check_vec("R8 flags", VEC_W'(chain_out), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R8 valid after release", out_valid, 1'b0);
        check_vec("R8 data after release", out_data, '0);

        // R1: all-ones + all-ones + 1
        run_op("R1 max add", 1'b0, fill('1), fill('1), '1, '1);
        // R2 / R3: 0 - 0 - 1 and max - max - 1 both borrow
        run_op("R2 R3 zero minus borrow", 1'b1, '0, '0, '1, '1);
        run_op("R3 max minus max minus one", 1'b1, fill('1), fill('1), '1, '1);
        run_op("R3 equal no borrow", 1'b1, fill(16'h0005), fill(16'h0005), '0, '1);
        // R4: masked lanes with large operands
        run_op("R4 all masked", 1'b0, fill('1), fill('1), '1, '0);
        run_op("R4 masked sub", 1'b1, '0, fill('1), '1, 8'b0101_0101);
        // R5: overflowing lane 0 beside a zero lane 1
        a = '0; b = '0;
        a[ELEM_W-1:0] = '1; b[ELEM_W-1:0] = 16'h0001;
        run_op("R5 no lateral carry", 1'b0, a, b, '0, '1);
        b = '0; b[ELEM_W-1:0] = 16'h0001;
        run_op("R5 no lateral borrow", 1'b1, '0, b, '0, '1);
        // R9: only lane 3 active, distinct pattern per lane
        for (int i = 0; i < LANES; i++) begin
            a[i*ELEM_W +: ELEM_W] = ELEM_W'(16'h1000 * (i + 1) + 16'hFF00);
            b[i*ELEM_W +: ELEM_W] = ELEM_W'(16'h0200 + i);
        end
        run_op("R9 lane 3 placement", 1'b0, a, b, 8'b0000_1000, 8'b0000_1000);

        // R7: idle cycle with changing inputs holds outputs
        @(negedge clk);
        opa = fill(16'h1357); opb = fill(16'h2468); chain_in = 8'hA5; op_sub = 1'b1;
        @(negedge clk);
        check_bit("R7 valid low", out_valid, 1'b0);
        check_vec("R7 data held", out_data, exp_y);
        check_vec("R7 flags held", VEC_W'(chain_out), VEC_W'(exp_f));

        // R1: two-step chain equals a wide add per lane pair of limbs
        a = fill(16'hFFF0); b = fill(16'h0020);
        run_op("R1 chain low limb", 1'b0, a, b, '0, '1);
        lo_y = out_data; lo_f = chain_out;
        run_op("R1 chain high limb", 1'b0, fill(16'h0001), fill(16'h0002), lo_f, '1);
        ref_y = fill(16'h0004);
        check_vec("R1 chained high limb", out_data, ref_y);
        check_vec("R1 chained low limb", lo_y, fill(16'h0010));

        // R6: back-to-back strobes present each result in turn
        @(negedge clk);
        in_valid = 1'b1; op_sub = 1'b0; opa = fill(16'h0003); opb = fill(16'h0004);
        chain_in = '0; lane_en = '1;
        @(negedge clk);
        check_vec("R6 first of pair", out_data, fill(16'h0007));
        opa = fill(16'h0010); op_sub = 1'b1; opb = fill(16'h0001);
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R6 second valid", out_valid, 1'b1);
        check_vec("R6 second of pair", out_data, fill(16'h000F));
        @(negedge clk);
        check_bit("R6 pulse ends", out_valid, 1'b0);

        // random mix for R1 R2 R3 R4
        for (int n = 0; n < 300; n++) begin
            logic [VEC_W-1:0] ra, rb;
            for (int i = 0; i < LANES; i++) begin
                ra[i*ELEM_W +: ELEM_W] = ELEM_W'($urandom);
                rb[i*ELEM_W +: ELEM_W] = ELEM_W'($urandom);
                if ($urandom % 8 == 0) rb[i*ELEM_W +: ELEM_W] = ra[i*ELEM_W +: ELEM_W];
            end
            run_op("R1 R2 R3 R4 random", 1'($urandom), ra, rb,
                   LANES'($urandom), LANES'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule